// File: doc/BRIEF.md
# Cipher Row-Shift and Byte-Substitution Stage

This stage applies the two byte-wise steps of an AES-128 round to a full 128-bit state in a single clock: it first reorders the sixteen bytes with the forward or inverse row-shift pattern, and then maps every byte through the forward or inverse S-box. A single direction input selects encryption or decryption for each state, so the same hardware serves both.

Both substitution tables are held in one 512-word by 8-bit synchronous read-only memory. The direction bit forms the top address bit. The table contents are computed at elaboration from the finite-field inverse and the affine map. The memory has sixteen read ports, so a whole state moves through every clock. Because the reads are registered, results appear one clock after the input is taken, and a valid flag travels alongside them.

Top module: `aes_shift_sub`

## Requirements
- R1: With `in_decrypt`=0, output byte p is the substitution of input byte FWD[p], where FWD = 0,5,a,f,4,9,e,3,8,d,2,7,c,1,6,b. Byte i of a state sits at bits [127-8i -: 8], so byte 0 is the most significant.
- R2: With `in_decrypt`=1, output byte p is the inverse substitution of input byte INV[p], where INV = 0,d,a,7,4,1,e,b,8,5,2,f,c,9,6,3.
- R3: The forward substitution is the AES S-box, for example 00→63 and 53→ed.
- R4: The inverse substitution is the inverse AES S-box, for example 63→00 and ed→53.
- R5: `out_state` shows the result for the inputs sampled at the previous rising clock edge, with exactly one cycle of latency. A new state may be applied on every cycle.
- R6: `out_valid` equals `in_valid` delayed by exactly one clock.
- R7: While `rst` is high at a clock edge, `out_valid` is 0 after that edge, whatever `in_valid` is.
- R8: The direction is sampled on the same edge as the data. Back-to-back states with opposite directions are each processed in their own direction.
- R9: Passing a state forward and then passing the result through the inverse direction returns the original state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the valid flag only |
| in_valid | input | 1 | Input state is valid |
| in_decrypt | input | 1 | 0 = forward (encrypt), 1 = inverse (decrypt) |
| in_state | input | 128 | Input state, byte 0 in bits 127:120 |
| out_valid | output | 1 | Output state is valid |
| out_state | output | 128 | Shifted and substituted state |

## Verification
Every result of this block, both data and valid, is due one clock after the edge that samples the inputs. The bench drives its inputs on a falling edge and compares at the next falling edge. That point lies after the single capturing rising edge and before the following one. The back-to-back and valid-pattern tests keep changing the inputs on every cycle, so an extra or missing register stage shows up as a value that lands one cycle early or late. The permutation is checked by placing one marked byte among filler bytes whose substitutions are known, so each output position is traced to its source.

// File: rtl/aes_ss_pkg.sv
package aes_ss_pkg;

  localparam int BYTE_W = 8;

  // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ((sh << 1) ^ 8'h1b) : (sh << 1);
    end
    return acc;
  endfunction

  // inverse by exponentiation a^254, zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] res  = 8'h01;
    logic [7:0] base = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) res = gf_mul(res, base);
      base = gf_mul(base, base);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  function automatic logic [7:0] fwd_sub(input logic [7:0] x);
    logic [7:0] b = gf_inv(x);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sub(input logic [7:0] x);
    return gf_inv(rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05);
  endfunction

  // table word: address msb selects the inverse table
  function automatic logic [7:0] table_word(input logic [8:0] addr);
    return addr[8] ? inv_sub(addr[7:0]) : fwd_sub(addr[7:0]);
  endfunction

  // source byte index for output position pos (4x4 column-major state)
  function automatic int shift_src(input int pos, input int nb, input bit dec);
    int step = 4 * (pos % 4);
    return dec ? ((pos + nb - step) % nb) : ((pos + step) % nb);
  endfunction

endpackage

// File: rtl/aes_row_shift.sv
module aes_row_shift #(
  parameter int NB = 16,
  parameter int BW = 8
) (
  input  logic             dec,
  input  logic [NB*BW-1:0] din,
  output logic [NB*BW-1:0] dout
);
  import aes_ss_pkg::*;

  for (genvar p = 0; p < NB; p++) begin : g_pos
    localparam int SRC_F = shift_src(p, NB, 1'b0);
    localparam int SRC_I = shift_src(p, NB, 1'b1);
    assign dout[(NB-1-p)*BW +: BW] = dec ? din[(NB-1-SRC_I)*BW +: BW]
                                         : din[(NB-1-SRC_F)*BW +: BW];
  end

endmodule

// File: rtl/aes_sub_rom.sv
module aes_sub_rom #(
  parameter int NPORTS = 16,
  parameter int AW     = 9,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORTS*AW-1:0] addr,
  output logic [NPORTS*DW-1:0] data
);
  import aes_ss_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] rom [DEPTH];

  initial begin
    for (int a = 0; a < DEPTH; a++) rom[a] = table_word(a[8:0]);
  end

  for (genvar k = 0; k < NPORTS; k++) begin : g_port
    always_ff @(posedge clk) begin
      data[k*DW +: DW] <= rom[addr[k*AW +: AW]];
    end
  end

  // R5
  rom_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (addr[AW-1:0] == $past(addr[AW-1:0])) |=> $stable(data[DW-1:0]));

endmodule

// File: rtl/aes_shift_sub.sv
module aes_shift_sub #(
  parameter int NB = 16,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_decrypt,
  input  logic [NB*BW-1:0] in_state,
  output logic             out_valid,
  output logic [NB*BW-1:0] out_state
);
  import aes_ss_pkg::*;

  localparam int SW = NB * BW;
  localparam int AW = BW + 1;

  logic [SW-1:0]    shifted;
  logic [NB*AW-1:0] rom_addr;

  aes_row_shift #(.NB(NB), .BW(BW)) u_shift (
    .dec  (in_decrypt),
    .din  (in_state),
    .dout (shifted)
  );

  for (genvar k = 0; k < NB; k++) begin : g_addr
    assign rom_addr[k*AW +: AW] = {in_decrypt, shifted[k*BW +: BW]};
  end

  aes_sub_rom #(.NPORTS(NB), .AW(AW), .DW(BW)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (rom_addr),
    .data (out_state)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R3 R4 R8: byte 0 keeps its position in both directions
  lane0_sub_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_state[SW-1 -: BW] ==
      ($past(in_decrypt) ? inv_sub($past(in_state[SW-1 -: BW]))
                         : fwd_sub($past(in_state[SW-1 -: BW]))));

endmodule

// File: tb/tb_aes_shift_sub.sv
`timescale 1ns/1ps
module tb_aes_shift_sub;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_decrypt = 1'b0;
  logic [127:0] in_state = '0;
  logic         out_valid;
  logic [127:0] out_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam int FWD [16] = '{0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11};
  localparam int INV [16] = '{0,13,10,7,4,1,14,11,8,5,2,15,12,9,6,3};

  always #2.5 clk = ~clk;

  aes_shift_sub dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_decrypt(in_decrypt),
    .in_state(in_state), .out_valid(out_valid), .out_state(out_state)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] fill(input logic [7:0] v);
    return {16{v}};
  endfunction

  function automatic logic [127:0] put(input logic [127:0] s, input int i,
                                       input logic [7:0] v);
    logic [127:0] r = s;
    r[127-8*i -: 8] = v;
    return r;
  endfunction

  // drive on a falling edge, result sampled one falling edge later
  task automatic apply(input logic [127:0] s, input bit dec, input bit v);
    in_state = s; in_decrypt = dec; in_valid = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 valid held low in reset", {127'd0, out_valid}, 128'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 valid low after reset", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic t_known;
    apply(fill(8'h00), 1'b0, 1'b1);
    check(out_state == fill(8'h63), "R3 00->63", out_state, fill(8'h63));
    apply(fill(8'h53), 1'b0, 1'b1);
    check(out_state == fill(8'hed), "R3 53->ed", out_state, fill(8'hed));
    apply(fill(8'h63), 1'b1, 1'b1);
    check(out_state == fill(8'h00), "R4 63->00", out_state, fill(8'h00));
    apply(fill(8'hed), 1'b1, 1'b1);
    check(out_state == fill(8'h53), "R4 ed->53", out_state, fill(8'h53));
  endtask

  task automatic t_fwd_perm;
    for (int j = 0; j < 16; j++) begin
      logic [127:0] exp = fill(8'h63);
      for (int p = 0; p < 16; p++) if (FWD[p] == j) exp = put(exp, p, 8'hed);
      apply(put(fill(8'h00), j, 8'h53), 1'b0, 1'b1);
      check(out_state == exp, "R1 forward byte route", out_state, exp);
    end
  endtask

  task automatic t_inv_perm;
    for (int j = 0; j < 16; j++) begin
      logic [127:0] exp = fill(8'h00);
      for (int p = 0; p < 16; p++) if (INV[p] == j) exp = put(exp, p, 8'h53);
      apply(put(fill(8'h63), j, 8'hed), 1'b1, 1'b1);
      check(out_state == exp, "R2 inverse byte route", out_state, exp);
    end
  endtask

  task automatic t_round_vector;
    logic [127:0] exp = 128'hd4bf5d30_e0b452ae_b84111f1_1e2798e5;
    apply(128'h193de3be_a0f4e22b_9ac68d2a_e9f84808, 1'b0, 1'b1);
    check(out_state == exp, "R1 R3 full round state", out_state, exp);
  endtask

  task automatic t_round_trip(input logic [127:0] s);
    logic [127:0] mid;
    apply(s, 1'b0, 1'b1);
    mid = out_state;
    apply(mid, 1'b1, 1'b1);
    check(out_state == s, "R9 forward then inverse", out_state, s);
  endtask

  task automatic t_back_to_back;
    logic [127:0] ea = put(fill(8'h63), 1, 8'hed);
    logic [127:0] eb = put(fill(8'h00), 9, 8'h53);
    apply(put(fill(8'h00), 5, 8'h53), 1'b0, 1'b1);
    in_state = put(fill(8'h63), 5, 8'hed); in_decrypt = 1'b1;
    check(out_state == ea, "R5 R8 first of pair (forward)", out_state, ea);
    @(negedge clk);
    check(out_state == eb, "R5 R8 second of pair (inverse)", out_state, eb);
  endtask

  task automatic t_valid;
    bit pat [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    foreach (pat[i]) begin
      apply(fill(8'h11), 1'b0, pat[i]);
      check(out_valid == pat[i], "R6 valid delayed one clock",
            {127'd0, out_valid}, {127'd0, pat[i]});
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_known;
    t_fwd_perm;
    t_inv_perm;
    t_round_vector;
    t_round_trip(128'h193de3be_a0f4e22b_9ac68d2a_e9f84808);
    t_round_trip(128'h00112233_44556677_8899aabb_ccddeeff);
    t_back_to_back;
    t_valid;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule